// File: doc/BRIEF.md
# Encrypted-Address Remap Buffer

This block translates user-mode data addresses that arrive as 64-bit ciphertext values. Such values are spread across the whole cipher space, so they cannot be used to index memory directly. The block gives each distinct ciphertext address a dense slot in a linear region that a supervisor configures. Slots are handed out one word at a time, in the order in which new addresses are installed.

A small fully associative cache holds the active mappings:
- On a hit, the block returns the linear address.
- On a miss, it returns a fault response. A supervisor handler then installs the mapping through a dedicated port and retries the access, which now hits.
- Supervisor-mode requests bypass translation and return their address unchanged.

Requests and responses are valid/ready streams with one response register between them:
- A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- The response appears on the next cycle.
- `req_ready` is high when the response register is empty or is being drained in that cycle, so a stalled consumer stalls the producer.
- While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.
- The configuration and install ports are plain single-cycle strobes with no handshake.

Top module: `enc_remap_top`

## Requirements
- R1: A supervisor request (`req_user`=0) that is accepted gives, one cycle later, a response with `rsp_fault`=0 and `rsp_addr` equal to `req_addr`.
- R2: A user request (`req_user`=1) whose address matches a resident mapping gives, one cycle later, `rsp_fault`=0 and `rsp_addr` equal to that mapping's linear address.
- R3: A user request with no resident mapping gives `rsp_fault`=1 and `rsp_addr`=0, and it leaves the mappings and the allocation pointer unchanged.
- R4: A privileged install with `inst_fresh`=1 maps `inst_tag` to the current `next_slot` value, and `next_slot` then advances by 8 (one word).
- R5: `region_full` is high when fewer than 8 bytes remain between `next_slot` and the configured limit. A fresh install while full is ignored: no mapping is made and `next_slot` holds.
- R6: A configuration write with `cfg_priv`=1 loads the base and limit, sets `next_slot` to the base and invalidates every mapping. With `cfg_priv`=0 the write has no effect.
- R7: An install with `inst_priv`=0 has no effect on the mappings or on `next_slot`.
- R8: When a new tag is installed and no entry holds it, the replaced entry is chosen round-robin, starting at entry 0 after reset or after reconfiguration. Once all entries are full, the oldest-filled entry is the first one replaced.
- R9: Installing a tag that is already resident rewrites that entry in place and does not move the round-robin pointer.
- R10: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While the response is stalled, `rsp_addr` and `rsp_fault` are held.
- R11: For user requests, `rsp_addr` bits 63:32 are always 0, because the linear region lies within the low 32-bit space.
- R12: After reset there are no mappings, `rsp_valid`=0, `next_slot`=0, and `region_full`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_user | input | 1 | 1 = user mode (translate), 0 = supervisor (bypass) |
| req_addr | input | 64 | Encrypted or plain data address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | User lookup missed |
| rsp_addr | output | 64 | Linear address, bypassed address, or 0 on fault |
| cfg_wr | input | 1 | Region configuration strobe |
| cfg_priv | input | 1 | Strobe comes from supervisor mode |
| cfg_base | input | 32 | First byte of the linear region |
| cfg_limit | input | 32 | End (exclusive) of the linear region |
| inst_valid | input | 1 | Mapping install strobe |
| inst_priv | input | 1 | Install comes from supervisor mode |
| inst_fresh | input | 1 | 1 = allocate `next_slot`, 0 = use `inst_lin` |
| inst_tag | input | 64 | Encrypted address to map |
| inst_lin | input | 32 | Linear address for a reload install |
| next_slot | output | 32 | Linear address the next fresh install will receive |
| region_full | output | 1 | No whole word remains in the region |

## Verification
Corrupted tag or valid state in the cache shows at the ports on the very next response. It appears as a fault where a hit was due, as a wrong linear address, or as an old mapping that still answers after a replacement or reconfiguration. A round-robin pointer that drifts appears only one install later, when the wrong resident tag starts to miss. For that reason the bench fills the cache completely, rewrites one resident tag, and then probes both the entry that should have been evicted and one that should have survived. Allocation-pointer faults appear on `next_slot` and `region_full` in the cycle after the install, and as a wrong linear address on the first lookup of the new tag.

// File: rtl/remap_pkg.sv
package remap_pkg;

  // Kind of response produced for an accepted request
  typedef enum logic [1:0] {
    RK_PASS = 2'd0,
    RK_HIT  = 2'd1,
    RK_MISS = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/remap_cam.sv
module remap_cam #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 64,
  parameter int LIN_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [LIN_W-1:0] lk_lin,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LIN_W-1:0] wr_lin
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             vld_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [LIN_W-1:0] lin_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec, wr_hit, wr_sel;
  logic [IDX_W-1:0] victim_q;
  logic wr_any;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      assign hit_vec[gi] = vld_q[gi] && (tag_q[gi] == lk_tag);
      assign wr_hit[gi]  = vld_q[gi] && (tag_q[gi] == wr_tag);
      assign wr_sel[gi]  = wr_any ? wr_hit[gi] : (victim_q == IDX_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[gi] <= 1'b0;
          tag_q[gi] <= '0;
          lin_q[gi] <= '0;
        end else if (clr) begin
          vld_q[gi] <= 1'b0;
        end else if (wr_en && wr_sel[gi]) begin
          vld_q[gi] <= 1'b1;
          tag_q[gi] <= wr_tag;
          lin_q[gi] <= wr_lin;
        end
      end
    end
  endgenerate

  assign wr_any = |wr_hit;
  assign lk_hit = |hit_vec;

  always_comb begin
    lk_lin = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_lin = lk_lin | lin_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_q <= '0;
    end else if (clr) begin
      victim_q <= '0;
    end else if (wr_en && !wr_any) begin
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end

  // R9
  uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  inplace_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_any && !clr) |=> $stable(victim_q));

  // R8
  victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_any && !clr && ENTRIES > 1) |=> (victim_q != $past(victim_q)));

  // R6
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lk_hit);

endmodule

// File: rtl/remap_alloc.sv
module remap_alloc #(
  parameter int LIN_W      = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [LIN_W-1:0] cfg_base,
  input  logic [LIN_W-1:0] cfg_limit,
  input  logic             take,
  output logic [LIN_W-1:0] slot,
  output logic             full
);
  localparam logic [LIN_W-1:0] STEP = LIN_W'(WORD_BYTES);

  logic [LIN_W-1:0] ptr_q, limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      limit_q <= '0;
    end else if (cfg_load) begin
      ptr_q   <= cfg_base;
      limit_q <= cfg_limit;
    end else if (take && !full) begin
      ptr_q <= ptr_q + STEP;
    end
  end

  assign slot = ptr_q;
  assign full = (ptr_q >= limit_q) || ((limit_q - ptr_q) < STEP);

  // R5
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_load) |=> (slot == $past(slot) + STEP));

  // R6
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (slot == $past(cfg_base)));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cfg_load) |=> $stable(slot));

endmodule

// File: rtl/enc_remap_top.sv
module enc_remap_top #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 64,
  parameter int LIN_W      = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              cfg_wr,
  input  logic              cfg_priv,
  input  logic [LIN_W-1:0]  cfg_base,
  input  logic [LIN_W-1:0]  cfg_limit,
  input  logic              inst_valid,
  input  logic              inst_priv,
  input  logic              inst_fresh,
  input  logic [ADDR_W-1:0] inst_tag,
  input  logic [LIN_W-1:0]  inst_lin,
  output logic [LIN_W-1:0]  next_slot,
  output logic              region_full
);
  import remap_pkg::*;

  logic             cfg_ok, inst_ok, take, accept, lk_hit;
  logic [LIN_W-1:0] lk_lin, wr_lin, slot;
  logic             full;
  rsp_kind_e        kind;

  logic              rv_q, rf_q;
  logic [ADDR_W-1:0] ra_q;

  assign cfg_ok  = cfg_wr && cfg_priv;
  assign inst_ok = inst_valid && inst_priv && !cfg_ok && (!inst_fresh || !full);
  assign take    = inst_ok && inst_fresh;
  assign wr_lin  = inst_fresh ? slot : inst_lin;

  remap_cam #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W), .LIN_W(LIN_W)) cam_i (
    .clk(clk), .rst_n(rst_n), .clr(cfg_ok),
    .lk_tag(req_addr), .lk_hit(lk_hit), .lk_lin(lk_lin),
    .wr_en(inst_ok), .wr_tag(inst_tag), .wr_lin(wr_lin)
  );

  remap_alloc #(.LIN_W(LIN_W), .WORD_BYTES(WORD_BYTES)) alloc_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_ok),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .take(take), .slot(slot), .full(full)
  );

  assign next_slot   = slot;
  assign region_full = full;
  assign req_ready   = !rv_q || rsp_ready;
  assign accept      = req_valid && req_ready;

  always_comb begin
    if (!req_user)   kind = RK_PASS;
    else if (lk_hit) kind = RK_HIT;
    else             kind = RK_MISS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rf_q <= 1'b0;
      ra_q <= '0;
    end else if (accept) begin
      rv_q <= 1'b1;
      unique case (kind)
        RK_PASS: begin rf_q <= 1'b0; ra_q <= req_addr; end
        RK_HIT:  begin rf_q <= 1'b0; ra_q <= ADDR_W'(lk_lin); end
        default: begin rf_q <= 1'b1; ra_q <= '0; end
      endcase
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_fault = rf_q;
  assign rsp_addr  = ra_q;

  // R1
  sup_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_user) |=> (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr)));

  // R11
  user_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_user) |=> (rsp_addr[ADDR_W-1:LIN_W] == '0));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

  // R7
  unpriv_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && !inst_priv && !cfg_ok) |=> $stable(next_slot));

endmodule

// File: tb/enc_remap_top_tb_top.sv
`timescale 1ns/1ps
module enc_remap_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_user = 0, rsp_ready = 1;
  logic [63:0] req_addr = '0;
  logic cfg_wr = 0, cfg_priv = 0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic inst_valid = 0, inst_priv = 0, inst_fresh = 0;
  logic [63:0] inst_tag = '0;
  logic [31:0] inst_lin = '0;
  logic req_ready, rsp_valid, rsp_fault, region_full;
  logic [63:0] rsp_addr;
  logic [31:0] next_slot;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  enc_remap_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_user(req_user), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .cfg_wr(cfg_wr), .cfg_priv(cfg_priv), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .inst_valid(inst_valid), .inst_priv(inst_priv), .inst_fresh(inst_fresh),
    .inst_tag(inst_tag), .inst_lin(inst_lin), .next_slot(next_slot),
    .region_full(region_full)
  );

  localparam logic [63:0] TA = 64'h9C3E_71A0_55D2_0B17;
  localparam logic [63:0] TB = 64'h0F4B_E2C9_3318_A6D5;
  localparam logic [63:0] TC = 64'h7A11_0C5E_D9B3_42F8;
  localparam logic [63:0] TD = 64'h3D6F_88A4_1E07_C95B;
  localparam logic [63:0] TE = 64'hB254_6E1D_0A93_F7C6;
  localparam logic [63:0] SA = 64'hDEAD_BEEF_0000_0010;

  // {user, address, expected fault, expected rsp_addr}
  localparam logic [129:0] VEC [8] = '{
    {1'b1, TA, 1'b0, 64'h1000},   // R2 R11
    {1'b1, TB, 1'b0, 64'h1008},   // R2
    {1'b1, TC, 1'b0, 64'h1010},   // R2
    {1'b1, TD, 1'b1, 64'h0},      // R3 R7 (unprivileged install ignored)
    {1'b0, SA, 1'b0, SA},         // R1
    {1'b1, 64'h0, 1'b1, 64'h0},   // R3
    {1'b0, TA, 1'b0, TA},         // R1
    {1'b1, TC, 1'b0, 64'h1010}    // R2 after a miss
  };

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", rq, got, exp);
    end
  endtask

  task automatic req(input logic u, input logic [63:0] a,
                     output logic v, output logic f, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1; req_user = u; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; f = rsp_fault; r = rsp_addr;
  endtask

  task automatic lookup(input string rq, input logic u, input logic [63:0] a,
                        input logic ef, input logic [63:0] ea);
    logic v, f;
    logic [63:0] r;
    req(u, a, v, f, r);
    chk({rq, " valid"}, 64'(v), 64'(1));
    chk({rq, " fault"}, 64'(f), 64'(ef));
    chk({rq, " addr"}, r, ea);
  endtask

  task automatic install(input logic p, input logic fr, input logic [63:0] t,
                         input logic [31:0] l);
    @(negedge clk);
    inst_valid = 1; inst_priv = p; inst_fresh = fr; inst_tag = t; inst_lin = l;
    @(negedge clk);
    inst_valid = 0;
  endtask

  task automatic config_wr(input logic p, input logic [31:0] b, input logic [31:0] l);
    @(negedge clk);
    cfg_wr = 1; cfg_priv = p; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R12 next_slot", 64'(next_slot), 64'(0));
    chk("R12 region_full", 64'(region_full), 64'(1));
    chk("R10 req_ready idle", 64'(req_ready), 64'(1));

    // R6 unprivileged configuration ignored
    config_wr(1'b0, 32'h5000, 32'h6000);
    chk("R6 unpriv cfg next_slot", 64'(next_slot), 64'(0));
    config_wr(1'b1, 32'h1000, 32'h1020);
    chk("R6 cfg next_slot", 64'(next_slot), 64'h1000);
    chk("R6 cfg not full", 64'(region_full), 64'(0));

    // R7 unprivileged install ignored
    install(1'b0, 1'b1, TD, 32'h0);
    chk("R7 unpriv install next_slot", 64'(next_slot), 64'h1000);

    // R4 fresh installs in order of first use
    install(1'b1, 1'b1, TA, 32'h0);
    install(1'b1, 1'b1, TB, 32'h0);
    install(1'b1, 1'b1, TC, 32'h0);
    chk("R4 next_slot after three", 64'(next_slot), 64'h1018);

    for (int i = 0; i < 8; i++) begin
      lookup($sformatf("vec%0d R1/R2/R3", i), VEC[i][129], VEC[i][128:65],
             VEC[i][64], VEC[i][63:0]);
    end

    // R5 last word fills the region
    install(1'b1, 1'b1, TD, 32'h0);
    chk("R4 next_slot after four", 64'(next_slot), 64'h1020);
    chk("R5 region_full", 64'(region_full), 64'(1));
    lookup("R4 fourth slot", 1'b1, TD, 1'b0, 64'h1018);
    install(1'b1, 1'b1, TE, 32'h0);
    chk("R5 full install next_slot", 64'(next_slot), 64'h1020);
    lookup("R5 full install ignored", 1'b1, TE, 1'b1, 64'h0);

    // R9 in-place rewrite of resident tag
    install(1'b1, 1'b0, TA, 32'h2000);
    lookup("R9 rewrite hits", 1'b1, TA, 1'b0, 64'h2000);

    // R8 round-robin: entry 0 (A) replaced
    install(1'b1, 1'b0, TE, 32'h3000);
    lookup("R8 new tag hits", 1'b1, TE, 1'b0, 64'h3000);
    lookup("R8 oldest evicted", 1'b1, TA, 1'b1, 64'h0);
    lookup("R8 R9 next kept", 1'b1, TB, 1'b0, 64'h1008);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_user = 0; req_addr = 64'h1111_2222_3333_4444;
    @(negedge clk);
    chk("R10 stalled valid", 64'(rsp_valid), 64'(1));
    chk("R10 ready low", 64'(req_ready), 64'(0));
    chk("R10 first addr", rsp_addr, 64'h1111_2222_3333_4444);
    req_addr = 64'h5555_6666_7777_8888;
    @(negedge clk);
    chk("R10 held addr", rsp_addr, 64'h1111_2222_3333_4444);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 second addr", rsp_addr, 64'h5555_6666_7777_8888);
    @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'(0));

    // R6 reconfigure clears mappings
    config_wr(1'b1, 32'h4000, 32'h4010);
    chk("R6 reload next_slot", 64'(next_slot), 64'h4000);
    chk("R6 reload not full", 64'(region_full), 64'(0));
    lookup("R6 mappings cleared", 1'b1, TE, 1'b1, 64'h0);
    install(1'b1, 1'b1, TB, 32'h0);
    lookup("R6 R11 new region", 1'b1, TB, 1'b0, 64'h4000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule